// File: doc/BRIEF.md
# UART Line-Setup Register Section with Busy Interlock

This block holds the line-control byte and the 16-bit baud divisor of a 16550-style UART. It sits between a simple register bus (address, write strobe, write data, combinational read data) and the serializer engines. It decides whether software writes to those settings are accepted. The serializer reports three busy sources: a frame leaving the transmitter, a frame arriving at the receiver, and a non-empty transmit FIFO. Any one of them marks the UART busy. While busy, setup writes are refused and a sticky flag records the refusal.

Software can instead enable a configure-while-busy mode. In that mode setup writes land in a shadow copy, and they reach the active settings only after software sets a self-clearing update bit. The swap happens in the first cycle in which neither shift engine is mid-frame. It replaces every setup byte in the same cycle, so the baud generator never sees a mix of old and new bytes. A build option removes the interlock altogether.

Two further controls help software reach an idle state. A loopback bit detaches the external receive line, but only once any frame being received has finished. A FIFO-control write clears both FIFOs, which removes the transmit-FIFO source of busy.

Top module: `uart_cfg_regs`

## Requirements
- R1: After reset the active line-control byte is 0x03, the divisor is 0x0001, loopback is off, no FIFO clear is signalled and the status register (address 5) reads 0x00 while all busy inputs are low.
- R2: Busy is high whenever tx_active, rx_active or txf_nonempty is high, and it reads as bit 0 of the status register (address 5).
- R3: While not busy, a write to the line-control register (address 3) takes effect at the next clock edge, and reading address 3 returns the byte currently in effect.
- R4: The divisor low byte (address 0) and high byte (address 1) are written and read only while bit 7 (latch access) of the written line-control value is 1. Otherwise writes to those addresses leave the divisor unchanged.
- R5: While busy, with configure-while-busy off and COMPAT=0, writes to line-control, divisor low or divisor high have no effect on the active settings.
- R6: A refused write sets status bit 1. It stays set until software writes status (address 5) with bit 1 set.
- R7: With configure-while-busy on (bit 0 of address 6), writes made while busy are held in a shadow copy. line_cfg and divisor stay unchanged, and no refusal is flagged.
- R8: Writing 1 to bit 1 of address 6 while configure-while-busy is on marks an update pending, and that bit reads back as 1. In the first cycle after that with tx_active and rx_active both low, all shadow bytes move into the active settings at one edge and the bit reads 0 again. A busy transmit FIFO alone does not delay the update.
- R9: With COMPAT=1 the setup registers are always writable, busy or not, and no refusal is flagged.
- R10: Setting bit 4 of the modem-control register (address 4) raises loop_on only at an edge where rx_active is low. Clearing the bit drops loop_on.
- R11: A write to the FIFO-control register (address 2) with bits 1 and 2 both set produces a one-cycle fifo_clear pulse in the cycle after the write. Other values produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (3) | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW (8) | Write data |
| rd_data | output | DW (8) | Combinational read data for addr |
| tx_active | input | 1 | Transmitter is shifting a frame |
| rx_active | input | 1 | Receiver is mid-frame |
| txf_nonempty | input | 1 | Transmit FIFO holds data |
| busy | output | 1 | OR of the three busy sources |
| line_cfg | output | DW (8) | Active line-control byte |
| divisor | output | 2*DW (16) | Active baud divisor, high byte above low byte |
| loop_on | output | 1 | Receive line detached for loopback |
| fifo_clear | output | 1 | One-cycle request to clear both FIFOs |

## Verification
The properties assume that tx_active and rx_active describe whole frames. They also assume the bus issues at most one write per cycle and holds wr_en low during reset. The bench drives the busy inputs and the bus only on falling edges, one write per cycle, and it models the FIFO as emptying only after a fifo_clear pulse. The check that settings change only between frames applies to the interlocked build. The bench therefore checks the COMPAT=1 instance through its ports alone.

// File: rtl/uart_cfg_pkg.sv
`timescale 1ns/1ps
package uart_cfg_pkg;
  localparam int A_DLL  = 0;
  localparam int A_DLM  = 1;
  localparam int A_FCR  = 2;
  localparam int A_LCR  = 3;
  localparam int A_MCR  = 4;
  localparam int A_STAT = 5;
  localparam int A_UPD  = 6;

  localparam int DLAB_BIT = 7;
  localparam int LOOP_BIT = 4;
  localparam int ST_BUSY  = 0;
  localparam int ST_BWD   = 1;
  localparam int UPD_CAB  = 0;
  localparam int UPD_GO   = 1;

  typedef enum logic [1:0] {WR_NONE, WR_ACCEPT, WR_STAGE, WR_BLOCK} wr_kind_e;

  // both FIFO-clear bits must be set together
  function automatic logic fcr_flush(input logic [1:0] clr_bits);
    return clr_bits[0] & clr_bits[1];
  endfunction

  function automatic logic is_setup_addr(input int a, input logic dlab);
    return (a == A_LCR) || (dlab && (a == A_DLL || a == A_DLM));
  endfunction
endpackage

// File: rtl/uart_cfg_gate.sv
`timescale 1ns/1ps
module uart_cfg_gate
  import uart_cfg_pkg::*;
#(
  parameter bit COMPAT = 1'b0
) (
  input  logic     tx_active,
  input  logic     rx_active,
  input  logic     txf_nonempty,
  input  logic     cab_en,
  input  logic     cfg_wr,
  output logic     busy,
  output logic     frame_idle,
  output logic     cab_eff,
  output wr_kind_e kind
);
  assign busy       = tx_active | rx_active | txf_nonempty;
  assign frame_idle = !tx_active && !rx_active;

  generate
    if (COMPAT) begin : g_free
      assign cab_eff = 1'b0;
      assign kind    = cfg_wr ? WR_ACCEPT : WR_NONE;
    end else begin : g_lock
      assign cab_eff = cab_en;
      always_comb begin
        if (!cfg_wr)      kind = WR_NONE;
        else if (!busy)   kind = WR_ACCEPT;
        else if (cab_en)  kind = WR_STAGE;
        else              kind = WR_BLOCK;
      end
    end
  endgenerate
endmodule

// File: rtl/uart_cfg_loop.sv
`timescale 1ns/1ps
module uart_cfg_loop (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_req,
  input  logic rx_active,
  output logic loop_on
);
  always_ff @(posedge clk) begin
    if (!rst_n)          loop_on <= 1'b0;
    else if (!loop_req)  loop_on <= 1'b0;
    else if (!rx_active) loop_on <= 1'b1;
  end
endmodule

// File: rtl/uart_cfg_regs.sv
`timescale 1ns/1ps
module uart_cfg_regs
  import uart_cfg_pkg::*;
#(
  parameter int        AW      = 3,
  parameter int        DW      = 8,
  parameter bit        COMPAT  = 1'b0,
  parameter logic [7:0]  LCR_RST = 8'h03,
  parameter logic [15:0] DIV_RST = 16'h0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic            tx_active,
  input  logic            rx_active,
  input  logic            txf_nonempty,
  output logic            busy,
  output logic [DW-1:0]   line_cfg,
  output logic [2*DW-1:0] divisor,
  output logic            loop_on,
  output logic            fifo_clear
);
  localparam int PADW = DW - 2;

  logic [DW-1:0] sh_lcr, sh_dll, sh_dlm, act_lcr, act_dll, act_dlm;
  logic [DW-1:0] sh_lcr_n, sh_dll_n, sh_dlm_n, act_lcr_n, act_dll_n, act_dlm_n;
  logic [DW-1:0] mcr_q;
  logic          cab_q, pend_q, bwd_q, flush_q;

  // named internal events
  logic     hit_lcr, hit_dll, hit_dlm, cfg_wr, frame_idle, cab_eff;
  logic     take, to_act, commit_now, upd_req, wr_blocked, bwd_clr;
  wr_kind_e kind;
  int       a_i;

  assign a_i     = int'(addr);
  assign hit_lcr = wr_en && a_i == A_LCR;
  assign hit_dll = wr_en && a_i == A_DLL && sh_lcr[DLAB_BIT];
  assign hit_dlm = wr_en && a_i == A_DLM && sh_lcr[DLAB_BIT];
  assign cfg_wr  = wr_en && is_setup_addr(a_i, sh_lcr[DLAB_BIT]);

  uart_cfg_gate #(.COMPAT(COMPAT)) u_gate (
    .tx_active    (tx_active),
    .rx_active    (rx_active),
    .txf_nonempty (txf_nonempty),
    .cab_en       (cab_q),
    .cfg_wr       (cfg_wr),
    .busy         (busy),
    .frame_idle   (frame_idle),
    .cab_eff      (cab_eff),
    .kind         (kind)
  );

  assign take       = (kind == WR_ACCEPT) || (kind == WR_STAGE);
  assign to_act     = (kind == WR_ACCEPT);
  assign wr_blocked = (kind == WR_BLOCK);
  assign commit_now = pend_q && frame_idle && cab_eff;
  assign upd_req    = wr_en && a_i == A_UPD && wr_data[UPD_GO] && cab_eff;
  assign bwd_clr    = wr_en && a_i == A_STAT && wr_data[ST_BWD];

  always_comb begin
    sh_lcr_n = sh_lcr;
    sh_dll_n = sh_dll;
    sh_dlm_n = sh_dlm;
    if (take && hit_lcr) sh_lcr_n = wr_data;
    if (take && hit_dll) sh_dll_n = wr_data;
    if (take && hit_dlm) sh_dlm_n = wr_data;
    // a commit moves every shadow byte at once
    act_lcr_n = commit_now ? sh_lcr_n : act_lcr;
    act_dll_n = commit_now ? sh_dll_n : act_dll;
    act_dlm_n = commit_now ? sh_dlm_n : act_dlm;
    if (to_act && hit_lcr) act_lcr_n = wr_data;
    if (to_act && hit_dll) act_dll_n = wr_data;
    if (to_act && hit_dlm) act_dlm_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_lcr  <= DW'(LCR_RST);
      act_lcr <= DW'(LCR_RST);
      sh_dll  <= DIV_RST[7:0];
      act_dll <= DIV_RST[7:0];
      sh_dlm  <= DIV_RST[15:8];
      act_dlm <= DIV_RST[15:8];
      mcr_q   <= '0;
      cab_q   <= 1'b0;
      pend_q  <= 1'b0;
      bwd_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      sh_lcr  <= sh_lcr_n;
      sh_dll  <= sh_dll_n;
      sh_dlm  <= sh_dlm_n;
      act_lcr <= act_lcr_n;
      act_dll <= act_dll_n;
      act_dlm <= act_dlm_n;
      if (wr_en && a_i == A_MCR) mcr_q <= wr_data;
      if (wr_en && a_i == A_UPD) cab_q <= wr_data[UPD_CAB];
      if (!cab_eff)        pend_q <= 1'b0;
      else if (upd_req)    pend_q <= 1'b1;
      else if (commit_now) pend_q <= 1'b0;
      if (wr_blocked)   bwd_q <= 1'b1;
      else if (bwd_clr) bwd_q <= 1'b0;
      flush_q <= wr_en && a_i == A_FCR && fcr_flush(wr_data[2:1]);
    end
  end

  uart_cfg_loop u_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_req  (mcr_q[LOOP_BIT]),
    .rx_active (rx_active),
    .loop_on   (loop_on)
  );

  always_comb begin
    rd_data = '0;
    case (a_i)
      A_DLL:  if (sh_lcr[DLAB_BIT]) rd_data = act_dll;
      A_DLM:  if (sh_lcr[DLAB_BIT]) rd_data = act_dlm;
      A_LCR:  rd_data = act_lcr;
      A_MCR:  rd_data = mcr_q;
      A_STAT: rd_data = {{PADW{1'b0}}, bwd_q, busy};
      A_UPD:  rd_data = {{PADW{1'b0}}, pend_q, cab_eff};
      default: rd_data = '0;
    endcase
  end

  assign line_cfg   = act_lcr;
  assign divisor    = {act_dlm, act_dll};
  assign fifo_clear = flush_q;
endmodule

// File: rtl/uart_cfg_regs_chk.sv
`timescale 1ns/1ps
module uart_cfg_regs_chk #(
  parameter bit COMPAT = 1'b0,
  parameter int DW     = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_active,
  input logic            rx_active,
  input logic [DW-1:0]   line_cfg,
  input logic [2*DW-1:0] divisor,
  input logic            loop_on,
  input logic            wr_blocked,
  input logic            bwd_q,
  input logic            pend_q,
  input logic            commit_now,
  input logic            upd_req
);
  AST_BLOCK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> ($stable(line_cfg) && $stable(divisor))); // R5

  AST_BWD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> bwd_q); // R6

  AST_CHANGE_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    (!COMPAT && (line_cfg != $past(line_cfg) || divisor != $past(divisor)))
      |-> $past(!tx_active && !rx_active)); // R8

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_now && !upd_req) |=> !pend_q); // R8

  AST_LOOP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_on) |-> $past(!rx_active)); // R10
endmodule

bind uart_cfg_regs uart_cfg_regs_chk #(.COMPAT(COMPAT), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_active  (tx_active),
  .rx_active  (rx_active),
  .line_cfg   (line_cfg),
  .divisor    (divisor),
  .loop_on    (loop_on),
  .wr_blocked (wr_blocked),
  .bwd_q      (bwd_q),
  .pend_q     (pend_q),
  .commit_now (commit_now),
  .upd_req    (upd_req)
);

// File: tb/uart_cfg_regs_bench.sv
`timescale 1ns/1ps
module uart_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        tx_a = 1'b0, rx_a = 1'b0, txf_ne = 1'b0;
  logic [7:0]  rd_data, rd_c, line_cfg, line_c;
  logic [15:0] divisor, div_c;
  logic        busy, busy_c, loop_on, loop_c, fclr, fclr_c;
  int checks = 0, errors = 0;
  logic timed_out = 1'b0;

  always #10 clk = ~clk;

  uart_cfg_regs u_uart_cfg_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tx_active(tx_a), .rx_active(rx_a), .txf_nonempty(txf_ne),
    .busy(busy), .line_cfg(line_cfg), .divisor(divisor), .loop_on(loop_on),
    .fifo_clear(fclr));

  uart_cfg_regs #(.COMPAT(1'b1)) u_uart_cfg_regs_compat (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_c), .tx_active(tx_a), .rx_active(rx_a), .txf_nonempty(txf_ne),
    .busy(busy_c), .line_cfg(line_c), .divisor(div_c), .loop_on(loop_c),
    .fifo_clear(fclr_c));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [7:0] dc);
    addr = a;
    #1;
    d = rd_data;
    dc = rd_c;
  endtask

  task automatic t_reset;
    logic [7:0] d, dc;
    rd(3'd5, d, dc);
    check("R1 line_cfg", {8'h0, line_cfg}, 16'h03);
    check("R1 divisor", divisor, 16'h0001);
    check("R1 loop_on", {15'h0, loop_on}, 16'h0);
    check("R1 fifo_clear", {15'h0, fclr}, 16'h0);
    check("R1 status", {8'h0, d}, 16'h00);
  endtask

  task automatic t_busy_sources;
    logic [7:0] d, dc;
    @(negedge clk); tx_a = 1'b1; rd(3'd5, d, dc);
    check("R2 busy from tx", {15'h0, d[0]}, 16'h1);
    @(negedge clk); tx_a = 1'b0; rx_a = 1'b1; rd(3'd5, d, dc);
    check("R2 busy from rx", {15'h0, busy}, 16'h1);
    @(negedge clk); rx_a = 1'b0; txf_ne = 1'b1; rd(3'd5, d, dc);
    check("R2 busy from fifo", {15'h0, d[0]}, 16'h1);
    @(negedge clk); txf_ne = 1'b0; rd(3'd5, d, dc);
    check("R2 idle", {15'h0, d[0]}, 16'h0);
  endtask

  task automatic t_idle_write;
    logic [7:0] d, dc;
    wr(3'd3, 8'h1B);
    check("R3 line_cfg", {8'h0, line_cfg}, 16'h1B);
    rd(3'd3, d, dc);
    check("R3 readback", {8'h0, d}, 16'h1B);
  endtask

  task automatic t_divisor;
    logic [7:0] d, dc;
    wr(3'd0, 8'h77);
    check("R4 no latch access", divisor, 16'h0001);
    wr(3'd3, 8'h9B);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    check("R4 divisor", divisor, 16'h1234);
    rd(3'd0, d, dc);
    check("R4 low readback", {8'h0, d}, 16'h34);
  endtask

  task automatic t_blocked;
    logic [7:0] d, dc;
    @(negedge clk); tx_a = 1'b1;
    wr(3'd0, 8'h99);
    wr(3'd3, 8'h03);
    check("R5 line_cfg held", {8'h0, line_cfg}, 16'h9B);
    check("R5 divisor held", divisor, 16'h1234);
    rd(3'd3, d, dc);
    check("R5 readback", {8'h0, d}, 16'h9B);
    rd(3'd5, d, dc);
    check("R6 flag set", {8'h0, d}, 16'h03);
    check("R9 compat divisor", div_c, 16'h1299);
    check("R9 compat line_cfg", {8'h0, line_c}, 16'h03);
    check("R9 compat no flag", {8'h0, dc}, 16'h01);
    repeat (3) @(negedge clk);
    rd(3'd5, d, dc);
    check("R6 flag sticky", {8'h0, d}, 16'h03);
    wr(3'd5, 8'h02);
    rd(3'd5, d, dc);
    check("R6 flag cleared", {8'h0, d}, 16'h01);
    @(negedge clk); tx_a = 1'b0;
  endtask

  task automatic t_staged;
    logic [7:0] d, dc;
    @(negedge clk); tx_a = 1'b1; rx_a = 1'b1;
    wr(3'd6, 8'h01);
    wr(3'd0, 8'hCD);
    wr(3'd1, 8'hAB);
    wr(3'd3, 8'h07);
    check("R7 line_cfg held", {8'h0, line_cfg}, 16'h9B);
    check("R7 divisor held", divisor, 16'h1234);
    rd(3'd5, d, dc);
    check("R7 no flag", {8'h0, d}, 16'h01);
    wr(3'd6, 8'h03);
    rd(3'd6, d, dc);
    check("R8 pending", {8'h0, d}, 16'h03);
    repeat (3) @(negedge clk);
    check("R7 still held", {8'h0, line_cfg}, 16'h9B);
    tx_a = 1'b0;
    @(negedge clk);
    check("R8 waits for rx", {8'h0, line_cfg}, 16'h9B);
    txf_ne = 1'b1; rx_a = 1'b0;
    @(negedge clk);
    check("R8 line_cfg applied", {8'h0, line_cfg}, 16'h07);
    check("R8 divisor applied", divisor, 16'hABCD);
    rd(3'd6, d, dc);
    check("R8 bit cleared", {8'h0, d}, 16'h01);
    txf_ne = 1'b0;
    wr(3'd6, 8'h00);
  endtask

  task automatic t_loop;
    @(negedge clk); rx_a = 1'b1;
    wr(3'd4, 8'h10);
    repeat (3) @(negedge clk);
    check("R10 waits for frame end", {15'h0, loop_on}, 16'h0);
    rx_a = 1'b0;
    @(negedge clk);
    check("R10 loop on", {15'h0, loop_on}, 16'h1);
    wr(3'd4, 8'h00);
    @(negedge clk);
    check("R10 loop off", {15'h0, loop_on}, 16'h0);
  endtask

  task automatic t_flush;
    logic [7:0] d, dc;
    @(negedge clk); txf_ne = 1'b1;
    rd(3'd5, d, dc);
    check("R2 fifo busy", {15'h0, d[0]}, 16'h1);
    wr(3'd2, 8'h06);
    check("R11 pulse", {15'h0, fclr}, 16'h1);
    txf_ne = 1'b0;
    @(negedge clk);
    check("R11 pulse ends", {15'h0, fclr}, 16'h0);
    rd(3'd5, d, dc);
    check("R11 busy gone", {15'h0, d[0]}, 16'h0);
    wr(3'd2, 8'h02);
    check("R11 partial no pulse", {15'h0, fclr}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_busy_sources();
        t_idle_write();
        t_divisor();
        t_blocked();
        t_staged();
        t_loop();
        t_flush();
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule